// File: doc/BRIEF.md
# Two-Wire DAC Command Serializer

This block sends a three-byte command to a bias-voltage DAC over a two-wire clock/data link. It never drives the wires. It produces a stream of 8-bit register writes, and a downstream serial-link interface delivers each write to a power-control register. In every written value one bit is the wire clock and one bit is the wire data. The other bits repeat a base pattern that the caller supplies, so that the remaining power-control enables hold their state while the link is toggled.

A one-cycle start strobe captures the base pattern and the value byte. The block then walks a fixed frame: a start condition, the device address byte, an acknowledge slot, the sub-address byte, an acknowledge slot, the value byte, an acknowledge slot and a stop condition. The link can only be written, so acknowledge slots are clocked with data low and nothing is read back.

Each write is presented on a valid/ready pair and held until it is accepted. After it is accepted the block waits a fixed settle time, counted in clock cycles, before it presents the next write. When the settle time after the final write has run out, a one-cycle done pulse is raised.

Top module: `dac_cmd_serializer`

## Requirements
- R1: While reset is asserted and in the first cycle after reset, `wr_valid_o` and `done_o` are low.
- R2: In every emitted value, bit 0 is the wire clock and bit 1 is the wire data. Bits 7:2 equal bits 7:2 of the base pattern captured at start. Base bits 1:0 have no effect.
- R3: A frame opens with three writes, with (clock, data) levels of (1,1), then (1,0), then (0,0).
- R4: Each data bit takes three writes, with clock levels 0, 1, 0. Data is held at the bit value for all three writes. Bytes are sent most significant bit first.
- R5: A frame is exactly 87 writes in this order: opening, byte 0x9C, ack slot, byte 0x00, ack slot, the value byte, ack slot, closing.
- R6: An acknowledge slot is one data-bit cycle (three writes) with data low.
- R7: A frame closes with three writes, with (clock, data) levels of (0,0), then (1,0), then (1,1).
- R8: While `wr_valid_o` is high and `wr_ready_i` is low, `wr_valid_o` stays high and `wr_data_o` is unchanged. The frame advances only on acceptance.
- R9: After each accepted write, `wr_valid_o` is low for exactly `SETTLE_CYC` cycles before the next write is presented.
- R10: A start strobe that arrives while a frame is in progress is ignored. Changes to the base and value inputs during a frame have no effect on that frame.
- R11: `done_o` is high for exactly one cycle per frame. It rises `SETTLE_CYC + 1` cycles after the final closing write is accepted, and `wr_valid_o` is low while it is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; accepted only when idle |
| base_i | input | 8 | Base pattern for the non-wire bits |
| value_i | input | 8 | DAC value byte |
| wr_valid_o | output | 1 | Register write is presented |
| wr_ready_i | input | 1 | Downstream accepts the write |
| wr_data_o | output | 8 | Register value to write |
| done_o | output | 1 | One-cycle pulse at the end of the frame |

## Verification
Frames are sent with value bytes 0x7D, 0x00 and 0xFF, so that alternating, all-low and all-high data levels are each compared write by write against a frame built independently in the bench. One base pattern has its two wire bits set, which exposes any leak of base bits into the clock or data positions. The frames run under three acceptance patterns: always ready, short stalls and long stalls. These separate correct hold-until-accepted behaviour from early advancing, and they check that the settle gap is measured from acceptance and not from presentation. One frame receives a second start strobe and new inputs partway through, to show that they are ignored and that no extra frame follows.

// File: rtl/dac_ser_pkg.sv
package dac_ser_pkg;
  typedef enum logic [1:0] {SEG_START, SEG_BYTE, SEG_STOP} seg_e;
  typedef enum logic [1:0] {ST_IDLE, ST_EMIT, ST_WAIT} state_e;

  localparam int BITS_PER_BYTE  = 8;
  localparam int SLOTS_PER_BYTE = BITS_PER_BYTE + 1;  // data bits plus ack slot
  localparam int PHASES         = 3;
  localparam int NBYTES         = 3;
endpackage

// File: rtl/dac_ser_settle.sv
module dac_ser_settle #(
  parameter int SETTLE_CYC = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  localparam int CW = $clog2(SETTLE_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!run_i)    cnt_q <= '0;
    else if (!expire_o) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == CW'(SETTLE_CYC - 1));

  assert_settle_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(SETTLE_CYC));
endmodule

// File: rtl/dac_ser_seq.sv
module dac_ser_seq
  import dac_ser_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  input  logic [BW-1:0] cur_byte_i,
  output logic [$clog2(NBYTES)-1:0] byte_idx_o,
  output logic          wire_clk_o,
  output logic          wire_dat_o,
  output logic          last_o
);
  localparam int IW = $clog2(NBYTES);
  localparam int SW = $clog2(SLOTS_PER_BYTE);
  localparam int PW = $clog2(PHASES);

  seg_e          seg_q;
  logic [IW-1:0] byte_q;
  logic [SW-1:0] slot_q;
  logic [PW-1:0] phase_q;

  logic phase_end, slot_end, byte_end, is_ack;
  logic [$clog2(BW)-1:0] bit_sel;

  assign phase_end = phase_q == PW'(PHASES - 1);
  assign slot_end  = slot_q == SW'(SLOTS_PER_BYTE - 1);
  assign byte_end  = byte_q == IW'(NBYTES - 1);
  assign is_ack    = slot_end;
  assign bit_sel   = $clog2(BW)'(BW - 1) - slot_q[$clog2(BW)-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q <= SEG_START; byte_q <= '0; slot_q <= '0; phase_q <= '0;
    end else if (clr_i) begin
      seg_q <= SEG_START; byte_q <= '0; slot_q <= '0; phase_q <= '0;
    end else if (adv_i) begin
      if (!phase_end) begin
        phase_q <= phase_q + 1'b1;
      end else begin
        phase_q <= '0;
        unique case (seg_q)
          SEG_START: begin seg_q <= SEG_BYTE; byte_q <= '0; slot_q <= '0; end
          SEG_BYTE: begin
            if (!slot_end) slot_q <= slot_q + 1'b1;
            else begin
              slot_q <= '0;
              if (byte_end) seg_q <= SEG_STOP;
              else          byte_q <= byte_q + 1'b1;
            end
          end
          default: seg_q <= SEG_STOP;
        endcase
      end
    end
  end

  always_comb begin
    unique case (seg_q)
      SEG_START: begin wire_clk_o = !phase_end; wire_dat_o = (phase_q == '0); end
      SEG_BYTE: begin
        wire_clk_o = (phase_q == PW'(1));
        wire_dat_o = is_ack ? 1'b0 : cur_byte_i[bit_sel];
      end
      default: begin wire_clk_o = (phase_q != '0); wire_dat_o = phase_end; end
    endcase
  end

  assign byte_idx_o = byte_q;
  assign last_o     = (seg_q == SEG_STOP) && phase_end;

  assert_phase_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q < PW'(PHASES));
  assert_slot_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q < SW'(SLOTS_PER_BYTE));
  assert_ack_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_q == SEG_BYTE && is_ack) |-> !wire_dat_o);
endmodule

// File: rtl/dac_cmd_serializer.sv
module dac_cmd_serializer
  import dac_ser_pkg::*;
#(
  parameter int         REG_W      = 8,
  parameter int         CLK_BIT    = 0,
  parameter int         DAT_BIT    = 1,
  parameter logic [7:0] DEV_ADDR   = 8'h9C,
  parameter logic [7:0] SUB_ADDR   = 8'h00,
  parameter int         SETTLE_CYC = 1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [REG_W-1:0] base_i,
  input  logic [7:0]       value_i,
  output logic             wr_valid_o,
  input  logic             wr_ready_i,
  output logic [REG_W-1:0] wr_data_o,
  output logic             done_o
);
  localparam int IW = $clog2(NBYTES);

  state_e           state_q;
  logic [REG_W-1:0] base_q;
  logic [7:0]       value_q;
  logic             last_q;
  logic             accept, launch, expire, seq_last, wire_clk, wire_dat;
  logic [IW-1:0]    byte_idx;
  logic [7:0]       frame_bytes [NBYTES];
  logic [7:0]       cur_byte;
  logic             unused_wire_base;

  assign launch = (state_q == ST_IDLE) && start_i;
  assign accept = wr_valid_o && wr_ready_i;

  assign frame_bytes[0] = DEV_ADDR;
  assign frame_bytes[1] = SUB_ADDR;
  assign frame_bytes[2] = value_q;
  assign cur_byte       = frame_bytes[byte_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      value_q <= '0;
      last_q  <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          base_q  <= base_i;
          value_q <= value_i;
          state_q <= ST_EMIT;
        end
        ST_EMIT: if (wr_ready_i) begin
          last_q  <= seq_last;
          state_q <= ST_WAIT;
        end
        default: if (expire) begin
          if (last_q) begin
            state_q <= ST_IDLE;
            done_o  <= 1'b1;
          end else begin
            state_q <= ST_EMIT;
          end
        end
      endcase
    end
  end

  dac_ser_seq #(.BW(8)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (launch),
    .adv_i      (accept),
    .cur_byte_i (cur_byte),
    .byte_idx_o (byte_idx),
    .wire_clk_o (wire_clk),
    .wire_dat_o (wire_dat),
    .last_o     (seq_last)
  );

  dac_ser_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (state_q == ST_WAIT),
    .expire_o (expire)
  );

  assign wr_valid_o = (state_q == ST_EMIT);

  for (genvar i = 0; i < REG_W; i++) begin : g_bits
    if (i == CLK_BIT) begin : g_clk
      assign wr_data_o[i] = wire_clk;
    end else if (i == DAT_BIT) begin : g_dat
      assign wr_data_o[i] = wire_dat;
    end else begin : g_base
      assign wr_data_o[i] = base_q[i];
    end
  end

  assign unused_wire_base = base_q[CLK_BIT] ^ base_q[DAT_BIT];

  assert_stall_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_data_o)));
  assert_settle_gap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !wr_valid_o);
  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !wr_valid_o);
endmodule

// File: tb/dac_cmd_serializer_test.sv
module dac_cmd_serializer_test;
  localparam int S = 5;
  localparam int NW = 87;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] base = '0;
  logic [7:0] value = '0;
  logic       ready = 1'b0;
  logic       valid, done;
  logic [7:0] data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [7:0] exp_w [NW];

  always #5 clk = ~clk;

  dac_cmd_serializer #(.SETTLE_CYC(S)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_i(base), .value_i(value),
    .wr_valid_o(valid), .wr_ready_i(ready), .wr_data_o(data), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Expected write stream built from the requirements
  task automatic build(input logic [7:0] b, input logic [7:0] v);
    logic [7:0] bytes [3];
    logic [7:0] hi;
    int n;
    bytes[0] = 8'h9C; bytes[1] = 8'h00; bytes[2] = v;
    hi = {b[7:2], 2'b00};
    n = 0;
    exp_w[n++] = hi | 8'h3; exp_w[n++] = hi | 8'h1; exp_w[n++] = hi;      // R3
    for (int k = 0; k < 3; k++) begin
      for (int s = 0; s < 9; s++) begin
        logic d;
        d = (s < 8) ? bytes[k][7-s] : 1'b0;                               // R4 / R6
        exp_w[n++] = hi | {6'b0, d, 1'b0};
        exp_w[n++] = hi | {6'b0, d, 1'b1};
        exp_w[n++] = hi | {6'b0, d, 1'b0};
      end
    end
    exp_w[n++] = hi; exp_w[n++] = hi | 8'h1; exp_w[n++] = hi | 8'h3;      // R7
  endtask

  function automatic string tag(input int idx);
    int p;
    if (idx < 3) return "R3";
    if (idx >= NW - 3) return "R7";
    p = ((idx - 3) % 27) / 3;
    return (p == 8) ? "R6/R5" : "R4/R2/R5";
  endfunction

  function automatic bit rdy(input int mode, input int k);
    case (mode)
      0: return 1'b1;
      1: return (k % 3) != 0;
      default: return (k % 7) >= 5;
    endcase
  endfunction

  task automatic run_frame(input logic [7:0] b, input logic [7:0] v, input int mode,
                           input bit intrude);
    int n = 0, gap = 0, dones = 0, k = 0;
    bit pend = 0, stalled = 0, fin = 0;
    logic [7:0] prev = '0;
    build(b, v);
    @(negedge clk);
    base = b; value = v; start = 1'b1; ready = 1'b0;
    while (!fin && k < 4000) begin
      @(negedge clk);
      k++;
      ready = rdy(mode, k);
      if (intrude && n == 30 && !stalled) begin
        start = 1'b1; base = ~b; value = ~v;       // R10 intrusion
      end else begin
        start = 1'b0;
      end
      #1;
      if (done) begin
        dones++;
        chk(!valid, "R11 valid during done", valid, 0);
        chk(gap == S, "R11 done delay", gap, S);
        fin = 1;
      end else if (valid) begin
        if (stalled) chk(data == prev, "R8 data held", data, prev);
        if (pend) begin
          chk(gap == S, "R9 settle gap", gap, S);
          pend = 0;
        end
        if (ready) begin
          if (n < NW) chk(data == exp_w[n], tag(n), data, exp_w[n]);
          n++; gap = 0; pend = 1; stalled = 0;
        end else begin
          stalled = 1; prev = data;
        end
      end else begin
        if (stalled) chk(1'b0, "R8 valid dropped", 0, 1);
        stalled = 0;
        gap++;
      end
    end
    start = 1'b0;
    chk(n == NW, "R5 write count", n, NW);
    chk(dones == 1, "R11 done count", dones, 1);
    begin
      int extra = 0;
      for (int t = 0; t < 20; t++) begin
        @(negedge clk); #1;
        if (valid || done) extra++;
      end
      chk(extra == 0, intrude ? "R10 no second frame" : "R11 single pulse", extra, 0);
    end
  endtask

  task automatic test_reset();
    #1;
    chk(!valid && !done, "R1 in reset", {valid, done}, 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!valid && !done, "R1 after reset", {valid, done}, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    test_reset();
    run_frame(8'hA4, 8'h7D, 0, 0);
    run_frame(8'hA7, 8'h00, 1, 0);   // R2 base wire bits set
    run_frame(8'h5B, 8'hFF, 2, 0);
    run_frame(8'h10, 8'h96, 1, 1);   // R10 mid-frame start
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule